// File: doc/BRIEF.md
# Memory Training Pattern Generator

This block sits in one byte-wide data slice of a DRAM PHY and produces the write data used while the read and write eyes are trained. Each beat it presents a 9-bit word: eight data lanes and one mask lane. Three pattern sources can be chosen: a beat-rate toggle, a pseudo-random sequence from a 16-bit LFSR, and a pattern loaded from registers that gives every lane its own 16-beat bit string. Any combination of the three may be enabled for one run.

A run begins with a start strobe. The enabled patterns are run one after another, and a per-beat advance strobe steps through their beats. The edge-detection logic outside the block measures a leading and a trailing eye edge for each pattern. It hands them back with an edge-valid strobe, and that strobe also closes the current pattern. The block keeps a merged window across the run: the largest leading edge and the smallest trailing edge seen. It pulses done once the last enabled pattern has been merged.

Top module: `train_patgen`

## Requirements
- R1: After reset, and whenever no run is active, beat_data is 0, burst_last is 0 and done is 0. lead_out resets to 0 and trail_out resets to all-ones.
- R2: In clock mode, beat k of the pattern carries 1 on all nine lanes when k is even and 0 when k is odd. Beat 0 is all ones.
- R3: LFSR mode uses a 16-bit Fibonacci register that holds 16'hACE1 on beat 0 of the pattern. Each beat it advances as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. Lane i carries state bit i. The register keeps advancing across burst boundaries.
- R4: In user mode, lane i on beat b carries user_bits[16*i + b], where b is the beat within the burst. Lanes 0 to 7 are DQ0 to DQ7 and lane 8 is the mask lane. The same 16 beats repeat in every burst.
- R5: Beat 0 of a pattern appears on the cycle after the accepted start, or after the edge_valid that opens that pattern. Each beat_adv moves the output on by one beat on the following cycle. burst_last is 1 exactly on beats 15, 31, 47 and so on.
- R6: Enabled patterns run in the order clock, LFSR, user, and disabled ones are skipped. The enables are latched when start is accepted.
- R7: On the cycle after each edge_valid during a run, lead_out is the maximum and trail_out is the minimum of all edges given so far in this run. An accepted start re-initialises them to 0 and all-ones.
- R8: done is a one-cycle pulse on the cycle after the edge_valid of the last enabled pattern. beat_data returns to 0 on that same cycle.
- R9: A start with no pattern enabled is ignored: no run begins and lead_out and trail_out keep their values.
- R10: A start during a run and an edge_valid outside a run are ignored.
- R11: When edge_valid and beat_adv arrive together, edge_valid wins and the next pattern opens at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_clock | input | 1 | Enable the toggle pattern |
| en_lfsr | input | 1 | Enable the LFSR pattern |
| en_user | input | 1 | Enable the register-loaded pattern |
| user_bits | input | 144 | User pattern, 16 bits per lane, lane 0 lowest |
| start | input | 1 | Begin a run |
| beat_adv | input | 1 | Advance one beat |
| edge_valid | input | 1 | Edges for the current pattern are valid; close the pattern |
| lead_in | input | 8 | Measured leading edge |
| trail_in | input | 8 | Measured trailing edge |
| beat_data | output | 9 | Lane data for the current beat, bit 8 is the mask lane |
| burst_last | output | 1 | Current beat is the last of a burst |
| done | output | 1 | Run complete pulse |
| lead_out | output | 8 | Merged leading edge |
| trail_out | output | 8 | Merged trailing edge |

## Verification
The bench builds the block with its default parameters: nine lanes, 16-beat bursts and 8-bit edges. With 8-bit edges, the extreme values 0 and 255 can be used as edge inputs, so the max and min merge is tested against its own reset values. Runs of up to 33 beats cross two burst boundaries. That exposes the LFSR carrying on across bursts, user data repeating in each burst, and burst_last on beats 15 and 31.

// File: rtl/patgen_pkg.sv
package patgen_pkg;
  typedef enum logic [1:0] {
    PAT_CLK  = 2'd0,
    PAT_LFSR = 2'd1,
    PAT_USER = 2'd2
  } pat_e;

  localparam int NUM_PAT = 3;

  function automatic pat_e first_of(input logic [NUM_PAT-1:0] m);
    if (m[0])      return PAT_CLK;
    else if (m[1]) return PAT_LFSR;
    else           return PAT_USER;
  endfunction
endpackage

// File: rtl/patgen_lfsr.sv
module patgen_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] state_n
);
  logic [W-1:0] state_q;

  always_comb begin
    state_n = state_q;
    if (load)      state_n = SEED;
    else if (step) state_n = {state_q[W-2:0], ^(state_q & TAPS)};
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= state_n;
  end
endmodule

// File: rtl/patgen_ctrl.sv
module patgen_ctrl import patgen_pkg::*; #(
  parameter int BEATS = 16,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_PAT-1:0] en,
  input  logic              start,
  input  logic              beat_adv,
  input  logic              edge_valid,
  output logic              active_q,
  output logic              active_n,
  output pat_e              pat_n,
  output logic [BEAT_W-1:0] beat_n,
  output logic              lfsr_load,
  output logic              lfsr_step,
  output logic              merge,
  output logic              clr,
  output logic              done
);
  pat_e               pat_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [NUM_PAT-1:0] en_q, en_n, rest;
  logic               done_n;

  always_comb begin
    active_n  = active_q;
    pat_n     = pat_q;
    beat_n    = beat_q;
    en_n      = en_q;
    lfsr_load = 1'b0;
    lfsr_step = 1'b0;
    merge     = 1'b0;
    clr       = 1'b0;
    done_n    = 1'b0;
    rest      = en_q & (3'b110 << pat_q);
    if (!active_q) begin
      if (start && |en) begin
        active_n  = 1'b1;
        en_n      = en;
        pat_n     = first_of(en);
        beat_n    = '0;
        lfsr_load = 1'b1;
        clr       = 1'b1;
      end
    end else if (edge_valid) begin
      merge = 1'b1;
      if (|rest) begin
        pat_n     = first_of(rest);
        beat_n    = '0;
        lfsr_load = 1'b1;
      end else begin
        active_n = 1'b0;
        done_n   = 1'b1;
      end
    end else if (beat_adv) begin
      beat_n    = (beat_q == BEAT_W'(BEATS-1)) ? '0 : beat_q + 1'b1;
      lfsr_step = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pat_q    <= PAT_CLK;
      beat_q   <= '0;
      en_q     <= '0;
      done     <= 1'b0;
    end else begin
      active_q <= active_n;
      pat_q    <= pat_n;
      beat_q   <= beat_n;
      en_q     <= en_n;
      done     <= done_n;
    end
  end
endmodule

// File: rtl/patgen_beat.sv
module patgen_beat import patgen_pkg::*; #(
  parameter int LANES  = 9,
  parameter int BEATS  = 16,
  parameter int LFSR_W = 16,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   active_n,
  input  pat_e                   pat_n,
  input  logic [BEAT_W-1:0]      beat_n,
  input  logic [LFSR_W-1:0]      lfsr_n,
  input  logic [LANES*BEATS-1:0] user_bits,
  output logic [LANES-1:0]       beat_data,
  output logic                   burst_last
);
  logic [LANES-1:0] lane_bits;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BEATS-1:0] lane_word;
    assign lane_word = user_bits[i*BEATS +: BEATS];
    always_comb begin
      case (pat_n)
        PAT_CLK:  lane_bits[i] = ~beat_n[0];
        PAT_LFSR: lane_bits[i] = lfsr_n[i];
        default:  lane_bits[i] = lane_word[beat_n];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active_n) begin
      beat_data  <= '0;
      burst_last <= 1'b0;
    end else begin
      beat_data  <= lane_bits;
      burst_last <= (beat_n == BEAT_W'(BEATS-1));
    end
  end
endmodule

// File: rtl/patgen_merge.sv
module patgen_merge #(
  parameter int EDGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              merge,
  input  logic [EDGE_W-1:0] lead_in,
  input  logic [EDGE_W-1:0] trail_in,
  output logic [EDGE_W-1:0] lead_q,
  output logic [EDGE_W-1:0] trail_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lead_q  <= '0;
      trail_q <= '1;
    end else if (merge) begin
      if (lead_in > lead_q)   lead_q  <= lead_in;
      if (trail_in < trail_q) trail_q <= trail_in;
    end
  end
endmodule

// File: rtl/train_patgen.sv
module train_patgen import patgen_pkg::*; #(
  parameter int LANES  = 9,
  parameter int BEATS  = 16,
  parameter int EDGE_W = 8,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int USER_W = LANES * BEATS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_clock,
  input  logic              en_lfsr,
  input  logic              en_user,
  input  logic [USER_W-1:0] user_bits,
  input  logic              start,
  input  logic              beat_adv,
  input  logic              edge_valid,
  input  logic [EDGE_W-1:0] lead_in,
  input  logic [EDGE_W-1:0] trail_in,
  output logic [LANES-1:0]  beat_data,
  output logic              burst_last,
  output logic              done,
  output logic [EDGE_W-1:0] lead_out,
  output logic [EDGE_W-1:0] trail_out
);
  logic              active_q, active_n, lfsr_load, lfsr_step, merge, clr;
  pat_e              pat_n;
  logic [BEAT_W-1:0] beat_n;
  logic [LFSR_W-1:0] lfsr_n;

  patgen_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk, .rst, .en({en_user, en_lfsr, en_clock}), .start, .beat_adv,
    .edge_valid, .active_q, .active_n, .pat_n, .beat_n, .lfsr_load,
    .lfsr_step, .merge, .clr, .done
  );

  patgen_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk, .rst, .load(lfsr_load), .step(lfsr_step), .state_n(lfsr_n)
  );

  patgen_beat #(.LANES(LANES), .BEATS(BEATS), .LFSR_W(LFSR_W)) u_beat (
    .clk, .rst, .active_n, .pat_n, .beat_n, .lfsr_n, .user_bits,
    .beat_data, .burst_last
  );

  patgen_merge #(.EDGE_W(EDGE_W)) u_merge (
    .clk, .rst, .clr, .merge, .lead_in, .trail_in,
    .lead_q(lead_out), .trail_q(trail_out)
  );
endmodule

// File: rtl/train_patgen_chk.sv
module train_patgen_chk #(
  parameter int LANES  = 9,
  parameter int EDGE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              en_any,
  input logic              active,
  input logic              edge_valid,
  input logic              done,
  input logic [LANES-1:0]  beat_data,
  input logic              burst_last,
  input logic [EDGE_W-1:0] lead_in,
  input logic [EDGE_W-1:0] trail_in,
  input logic [EDGE_W-1:0] lead_out,
  input logic [EDGE_W-1:0] trail_out
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !active |-> (beat_data == '0) && !burst_last);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_merge_bound_R7: assert property (@(posedge clk) disable iff (rst)
    active && edge_valid |=> (lead_out >= $past(lead_in)) && (trail_out <= $past(trail_in)));

  assert_window_narrows_R7: assert property (@(posedge clk) disable iff (rst)
    active && $past(active) |-> (lead_out >= $past(lead_out)) && (trail_out <= $past(trail_out)));

  assert_noen_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    !active && start && !en_any |=> !active && $stable(lead_out) && $stable(trail_out));
endmodule

bind train_patgen train_patgen_chk #(.LANES(LANES), .EDGE_W(EDGE_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .en_any(en_clock | en_lfsr | en_user),
  .active(active_q), .edge_valid(edge_valid), .done(done),
  .beat_data(beat_data), .burst_last(burst_last), .lead_in(lead_in),
  .trail_in(trail_in), .lead_out(lead_out), .trail_out(trail_out)
);

// File: tb/train_patgen_bench.sv
module train_patgen_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic en_clock = 0, en_lfsr = 0, en_user = 0;
  logic [143:0] user_bits = {16'h5A3C, 32'h0F1E2D3C, 32'h4B5A6978, 32'h8796A5B4, 32'hC3D2E1F0};
  logic start = 0, beat_adv = 0, edge_valid = 0;
  logic [7:0] lead_in = 0, trail_in = 0, lead_out, trail_out;
  logic [8:0] beat_data;
  logic burst_last, done;

  typedef struct { logic [8:0] d; logic last; logic dn; logic [7:0] ld; logic [7:0] tr; string tag; } item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;
  logic [7:0] m_lead = 8'h00, m_trail = 8'hFF;
  bit finished = 0;

  always #5 clk = ~clk;

  train_patgen u_train_patgen (.*);

  function automatic logic [8:0] exp_beat(input int p, input int k);
    logic [15:0] s;
    logic [8:0] r;
    if (p == 0) return {9{~k[0]}};
    if (p == 1) begin
      s = 16'hACE1;
      for (int n = 0; n < k; n++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      return s[8:0];
    end
    for (int i = 0; i < 9; i++) r[i] = user_bits[i*16 + (k % 16)];
    return r;
  endfunction

  function automatic int first_en(input logic [2:0] e);
    if (e[0]) return 0;
    if (e[1]) return 1;
    return 2;
  endfunction

  // driver: applies one cycle of stimulus and queues the expected outcome
  task automatic drive(input logic s, a, e, input logic [7:0] li, ti,
                       input logic [8:0] d, input logic l, dn, input string tag);
    item_t it;
    @(negedge clk);
    start = s; beat_adv = a; edge_valid = e; lead_in = li; trail_in = ti;
    it.d = d; it.last = l; it.dn = dn; it.ld = m_lead; it.tr = m_trail; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic start_run(input logic [2:0] e, input string tag);
    {en_user, en_lfsr, en_clock} = e;
    if (e != 0) begin
      m_lead = 8'h00; m_trail = 8'hFF;
      drive(1, 0, 0, 0, 0, exp_beat(first_en(e), 0), 0, 0, tag);
    end else
      drive(1, 0, 0, 0, 0, 9'h0, 0, 0, tag);
  endtask

  task automatic run_pat(input int p, input int k0, input int k1, input string tag);
    for (int k = k0; k <= k1; k++) drive(0, 1, 0, 0, 0, exp_beat(p, k), (k % 16) == 15, 0, tag);
  endtask

  task automatic finish_pat(input int nxt, input logic [7:0] le, te, input logic adv, input string tag);
    if (le > m_lead) m_lead = le;
    if (te < m_trail) m_trail = te;
    if (nxt >= 0) drive(0, adv, 1, le, te, exp_beat(nxt, 0), 0, 0, tag);
    else          drive(0, adv, 1, le, te, 9'h0, 0, 1, tag);
  endtask

  task automatic idle(input string tag);
    drive(0, 0, 0, 0, 0, 9'h0, 0, 0, tag);
  endtask

  // monitor: pops one expectation per cycle, after the edge has settled
  initial forever begin
    item_t it;
    @(posedge clk); #2;
    if (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      checks++;
      if (beat_data !== it.d || burst_last !== it.last || done !== it.dn ||
          lead_out !== it.ld || trail_out !== it.tr) begin
        errors++;
        $display("FAIL %s: got data=%h last=%b done=%b lead=%0d trail=%0d, expected data=%h last=%b done=%b lead=%0d trail=%0d",
                 it.tag, beat_data, burst_last, done, lead_out, trail_out,
                 it.d, it.last, it.dn, it.ld, it.tr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    idle("R1 reset state");
    start_run(3'b000, "R9 start without enables");
    idle("R9 still idle");
    // clock pattern, with a stray start mid-run
    start_run(3'b001, "R2 clock beat0");
    run_pat(0, 1, 5, "R2 clock");
    drive(1, 0, 0, 0, 0, exp_beat(0, 5), 0, 0, "R10 start during run");
    run_pat(0, 6, 17, "R5 clock across burst");
    finish_pat(-1, 8'd10, 8'd200, 0, "R8 done after clock");
    idle("R8 done drops");
    drive(0, 0, 1, 8'd99, 8'd1, 9'h0, 0, 0, "R10 edge while idle");
    // LFSR pattern across bursts, extreme edges
    start_run(3'b010, "R3 lfsr seed");
    run_pat(1, 1, 20, "R3 lfsr");
    finish_pat(-1, 8'd0, 8'd255, 0, "R7 extreme edges");
    // user pattern repeated over bursts
    start_run(3'b100, "R4 user beat0");
    run_pat(2, 1, 33, "R4 user");
    finish_pat(-1, 8'd255, 8'd0, 0, "R7 user edges");
    // all three patterns in order
    start_run(3'b111, "R6 all start");
    run_pat(0, 1, 3, "R6 clock");
    finish_pat(1, 8'd20, 8'd180, 0, "R6 to lfsr");
    run_pat(1, 1, 3, "R3 lfsr reseeded");
    finish_pat(2, 8'd35, 8'd190, 1, "R11 edge beats advance");
    run_pat(2, 1, 2, "R6 user");
    finish_pat(-1, 8'd5, 8'd150, 0, "R7 merged 35/150");
    idle("R8 idle after all");
    // lfsr + user skips clock
    start_run(3'b110, "R6 skip clock");
    run_pat(1, 1, 2, "R3 lfsr");
    finish_pat(2, 8'd40, 8'd100, 0, "R6 to user");
    finish_pat(-1, 8'd30, 8'd120, 0, "R7 merged 40/100");
    start_run(3'b000, "R9 edges kept");
    idle("R9 edges kept idle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule